// File: doc/BRIEF.md
# Banked GPIO Register File with Keyed Write Protection

This block is the register side of a general-purpose pin controller. Pins are grouped into banks of 32, with up to eight banks. Software reaches every pin through a simple 32-bit register bus. Each pin has its own stored control word, and bit 0 of that word chooses the pin's direction. Output levels never take a written value directly. They move only through a set register and a clear register, so changing one pin cannot disturb its neighbours in the same bank. The block drives the pad output and output-enable lines. It returns the pad inputs after a two-flop synchroniser.

Each bank has a protect register with one bit per pin, where a 1 marks the pin as locked. A locked pin ignores set, clear and control-word writes. The protect register itself accepts a write only when the write immediately follows a password write to a key register. Any other bus write disarms the key. After reset every bank is fully locked, so the first act of software is always to unlock, using a key write followed by a protect write.

The bus has no back-pressure and never stalls. A write takes effect at the clock edge that samples it. A read returns its data with a valid pulse one cycle after the request. Interrupt detection and debounce are outside this block. Their offsets read as zero and ignore writes.

Top module: `gpio_lockbank`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all 0), `pad_out` is all 0, every protect register reads 0xFFFFFFFF and every control word reads 0x00000001.
- R2: Byte offsets, where b is a bank and p is a pin (bank = p >> 5, bit = p & 31):
  - output status at 0x000+4b
  - input status at 0x020+4b
  - set register at 0x040+4b
  - clear register at 0x060+4b
  - control word at 0x100+4p
  - protect register at 0x500+4b
  - key register at 0x520
- R3: In a write to a set register, each 1 bit whose pin is unlocked drives that pin's output latch to 1 at the sampling edge. Zero bits have no effect.
- R4: In a write to a clear register, each 1 bit whose pin is unlocked drives that pin's output latch to 0 at the sampling edge. Zero bits have no effect.
- R5: Control word bit 0 set to 1 makes a pin an input (`pad_oe` 0). Set to 0, it makes the pin an output (`pad_oe` 1). `pad_out` always shows the output latch, and output status reads the latch back.
- R6: Writing 0x00A5A501 to the key register arms the key. A protect-register write made as the very next bus write loads the written value, and that write consumes the key.
- R7: A protect-register write is ignored unless the key is armed. Any bus write other than the password write disarms the key, including a wrong value written to the key register.
- R8: Set, clear and control-word writes to locked pins are dropped. Unlocked pins in the same write still take effect. Reads are never blocked.
- R9: Input status returns the pad input through two flops. A read captured at the first or second rising edge after a pad change returns the old value. A read captured at the third edge returns the new value.
- R10: A read returns `rd_valid` high with `rd_data` one cycle after the request, and `rd_valid` is low otherwise. The following read as zero:
  - set, clear and key offsets
  - offsets 0x080 to 0x0FF
  - any bank or pin beyond NUM_BANKS

  Writes to banks beyond NUM_BANKS change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address, byte offset bits [11:2] |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| pad_in | input | 32*NUM_BANKS | Pad input levels |
| pad_out | output | 32*NUM_BANKS | Pad output levels (output latch) |
| pad_oe | output | 32*NUM_BANKS | Pad output enable, 1 = driving |

## Verification
Two things can land on the same edge. One is the synchroniser shifting in a fresh pad value; the other is a bus read of input status. The bench changes `pad_in` in the same half-cycle in which it issues the read. It then reads again on each of the next two edges and expects the old value, the old value, then the new value. Key disarming and protection are also provoked back to back: a set write or a wrong password sits between the key write and the protect write, and the bench judges by reading the protect register back and watching `pad_out` on partly locked banks.

// File: rtl/gpio_lockbank_pkg.sv
package gpio_lockbank_pkg;
  localparam int unsigned BANK_PINS = 32;
  localparam int unsigned MAX_BANKS = 8;
  localparam logic [31:0] KEY_PASSWORD = 32'h00A5_A501;
  localparam logic [11:0] KEY_OFFSET   = 12'h520;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_OUT_ST,
    RG_IN_ST,
    RG_SET,
    RG_CLR,
    RG_ZERO,
    RG_CTRL,
    RG_PROT,
    RG_KEY
  } reg_sel_e;
endpackage

// File: rtl/gpio_lockbank_dec.sv
module gpio_lockbank_dec
  import gpio_lockbank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8
) (
  input  logic [11:2] addr,
  output reg_sel_e    sel,
  output logic [2:0]  bank,
  output logic [4:0]  bit_idx,
  output logic        bank_ok
);
  logic [6:0] grp;
  logic [7:0] pin_off;

  assign grp     = addr[11:5];
  assign pin_off = addr[9:2] - 8'h40;

  always_comb begin
    sel     = RG_NONE;
    bank    = addr[4:2];
    bit_idx = '0;
    if (grp < 7'h08) begin
      case (grp[2:0])
        3'd0: sel = RG_OUT_ST;
        3'd1: sel = RG_IN_ST;
        3'd2: sel = RG_SET;
        3'd3: sel = RG_CLR;
        3'd4, 3'd5, 3'd6: sel = RG_ZERO;
        default: sel = RG_NONE;
      endcase
    end else if (grp < 7'h28) begin
      sel     = RG_CTRL;
      bank    = pin_off[7:5];
      bit_idx = pin_off[4:0];
    end else if (grp == 7'h28) begin
      sel = RG_PROT;
    end else if (addr == KEY_OFFSET[11:2]) begin
      sel  = RG_KEY;
      bank = '0;
    end
  end

  assign bank_ok = (int'(bank) < int'(NUM_BANKS));
endmodule

// File: rtl/gpio_lockbank_key.sv
module gpio_lockbank_key
  import gpio_lockbank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned PINS = NUM_BANKS * BANK_PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  reg_sel_e        sel,
  input  logic [2:0]      bank,
  input  logic [31:0]     wdata,
  output logic            key_armed,
  output logic [PINS-1:0] lock_all
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_armed <= 1'b0;
    end else if (wr_stb) begin
      key_armed <= (sel == RG_KEY) && (wdata == KEY_PASSWORD);
    end
  end

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_prot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lock_all[b*BANK_PINS +: BANK_PINS] <= '1;
      end else if (wr_stb && key_armed && (sel == RG_PROT) && (int'(bank) == b)) begin
        lock_all[b*BANK_PINS +: BANK_PINS] <= wdata;
      end
    end
  end
endmodule

// File: rtl/gpio_lockbank_bank.sv
module gpio_lockbank_bank
  import gpio_lockbank_pkg::*;
#(
  parameter int unsigned CTRL_W      = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_stb,
  input  logic              clr_stb,
  input  logic              ctrl_we,
  input  logic [4:0]        ctrl_bit,
  input  logic [31:0]       wdata,
  input  logic [31:0]       lock,
  input  logic [31:0]       pad_in,
  output logic [31:0]       out_q,
  output logic [31:0]       in_sync,
  output logic [31:0]       dir_in,
  output logic [CTRL_W-1:0] ctrl_rd
);
  localparam logic [CTRL_W-1:0] CTRL_RESET = CTRL_W'(1);

  logic [31:0]       open_bits;
  logic [31:0]       sync_q [SYNC_STAGES];
  logic [CTRL_W-1:0] ctrl_q [BANK_PINS];

  assign open_bits = wdata & ~lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (set_stb) begin
      out_q <= out_q | open_bits;
    end else if (clr_stb) begin
      out_q <= out_q & ~open_bits;
    end
  end

  for (genvar s = 0; s < int'(SYNC_STAGES); s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync_q[s] <= '0;
      end else begin
        sync_q[s] <= (s == 0) ? pad_in : sync_q[(s == 0) ? 0 : s-1];
      end
    end
  end
  assign in_sync = sync_q[SYNC_STAGES-1];

  for (genvar p = 0; p < int'(BANK_PINS); p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctrl_q[p] <= CTRL_RESET;
      end else if (ctrl_we && (int'(ctrl_bit) == p) && !lock[p]) begin
        ctrl_q[p] <= wdata[CTRL_W-1:0];
      end
    end
    assign dir_in[p] = ctrl_q[p][0];
  end

  assign ctrl_rd = ctrl_q[ctrl_bit];
endmodule

// File: rtl/gpio_lockbank.sv
module gpio_lockbank
  import gpio_lockbank_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 8,
  parameter int unsigned CTRL_W      = 9,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned PINS = NUM_BANKS * BANK_PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_en,
  input  logic            bus_we,
  input  logic [11:2]     bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic            rd_valid,
  output logic [31:0]     rd_data,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);
  logic        wr_stb;
  logic        rd_stb;
  reg_sel_e    sel;
  logic [2:0]  bank;
  logic [4:0]  bit_idx;
  logic        bank_ok;
  logic        key_armed;
  logic [PINS-1:0] lock_all;
  logic [31:0] rd_next;

  logic [31:0]       out_b  [NUM_BANKS];
  logic [31:0]       in_b   [NUM_BANKS];
  logic [31:0]       dir_b  [NUM_BANKS];
  logic [31:0]       lock_b [NUM_BANKS];
  logic [CTRL_W-1:0] ctrl_b [NUM_BANKS];

  assign wr_stb = bus_en & bus_we;
  assign rd_stb = bus_en & ~bus_we;

  gpio_lockbank_dec #(.NUM_BANKS(NUM_BANKS)) dec_i (
    .addr    (bus_addr),
    .sel     (sel),
    .bank    (bank),
    .bit_idx (bit_idx),
    .bank_ok (bank_ok)
  );

  gpio_lockbank_key #(.NUM_BANKS(NUM_BANKS)) key_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .sel       (sel),
    .bank      (bank),
    .wdata     (bus_wdata),
    .key_armed (key_armed),
    .lock_all  (lock_all)
  );

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    logic hit;
    assign hit       = wr_stb && (int'(bank) == b);
    assign lock_b[b] = lock_all[b*BANK_PINS +: BANK_PINS];

    gpio_lockbank_bank #(.CTRL_W(CTRL_W), .SYNC_STAGES(SYNC_STAGES)) bank_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_stb  (hit && (sel == RG_SET)),
      .clr_stb  (hit && (sel == RG_CLR)),
      .ctrl_we  (hit && (sel == RG_CTRL)),
      .ctrl_bit (bit_idx),
      .wdata    (bus_wdata),
      .lock     (lock_b[b]),
      .pad_in   (pad_in[b*BANK_PINS +: BANK_PINS]),
      .out_q    (out_b[b]),
      .in_sync  (in_b[b]),
      .dir_in   (dir_b[b]),
      .ctrl_rd  (ctrl_b[b])
    );

    assign pad_out[b*BANK_PINS +: BANK_PINS] = out_b[b];
    assign pad_oe[b*BANK_PINS +: BANK_PINS]  = ~dir_b[b];
  end

  always_comb begin
    rd_next = '0;
    if (bank_ok) begin
      case (sel)
        RG_OUT_ST: rd_next = out_b[bank];
        RG_IN_ST:  rd_next = in_b[bank];
        RG_CTRL:   rd_next = 32'(ctrl_b[bank]);
        RG_PROT:   rd_next = lock_b[bank];
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) begin
        rd_data <= rd_next;
      end
    end
  end
endmodule

// File: rtl/gpio_lockbank_chk.sv
module gpio_lockbank_chk
  import gpio_lockbank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 8,
  localparam int unsigned PINS = NUM_BANKS * BANK_PINS
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_en,
  input logic            bus_we,
  input logic [11:2]     bus_addr,
  input logic [31:0]     bus_wdata,
  input logic            rd_valid,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_oe,
  input logic [PINS-1:0] lock_all,
  input logic            key_armed
);
  logic            wr;
  logic            pw_write;
  logic [2:0]      wbank;
  logic [PINS-1:0] set_req;
  logic [PINS-1:0] clr_req;

  assign wr       = bus_en && bus_we;
  assign pw_write = wr && (bus_addr == KEY_OFFSET[11:2]) && (bus_wdata == KEY_PASSWORD);
  assign wbank    = bus_addr[4:2];

  always_comb begin
    set_req = '0;
    clr_req = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (wr && (int'(wbank) == b) && (bus_addr[11:5] == 7'h02))
        set_req[b*BANK_PINS +: BANK_PINS] = bus_wdata & ~lock_all[b*BANK_PINS +: BANK_PINS];
      if (wr && (int'(wbank) == b) && (bus_addr[11:5] == 7'h03))
        clr_req[b*BANK_PINS +: BANK_PINS] = bus_wdata & ~lock_all[b*BANK_PINS +: BANK_PINS];
    end
  end

  // R3
  set_reaches_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & $past(set_req)) == $past(set_req)));

  // R4
  clear_reaches_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & $past(clr_req)) == '0));

  // R8
  locked_out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & $past(lock_all)) == ($past(pad_out) & $past(lock_all))));

  // R8
  locked_dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & $past(lock_all)) == ($past(pad_oe) & $past(lock_all))));

  // R7
  lock_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_all != $past(lock_all)) |-> $past(key_armed));

  // R6
  arm_by_password_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_armed) |-> $past(pw_write));

  // R7
  other_write_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !pw_write) |=> !key_armed);

  // R10
  read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we) |=> rd_valid);

  // R10
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_we) |=> !rd_valid);
endmodule

bind gpio_lockbank gpio_lockbank_chk #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rd_valid  (rd_valid),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .lock_all  (lock_all),
  .key_armed (key_armed)
);

// File: tb/gpio_lockbank_tb_top.sv
`timescale 1ns/1ps
module gpio_lockbank_tb_top;
  localparam int NB   = 2;
  localparam int NP   = NB * 32;
  localparam logic [31:0] PW = 32'h00A5_A501;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0;
  logic          bus_we = 1'b0;
  logic [11:2]   bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [NP-1:0] m_out;
  logic [NP-1:0] m_lock;
  logic [8:0]    m_ctrl [NP];
  bit            m_armed;

  always #4 clk = ~clk;

  gpio_lockbank #(.NUM_BANKS(NB), .CTRL_W(9), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void model_write(input logic [11:0] a, input logic [31:0] d);
    int b = int'(a[4:2]);
    bit nxt = (a == 12'h520) && (d == PW);
    if (a[11:5] == 7'h02 && b < NB)
      for (int i = 0; i < 32; i++) if (d[i] && !m_lock[b*32+i]) m_out[b*32+i] = 1'b1;
    if (a[11:5] == 7'h03 && b < NB)
      for (int i = 0; i < 32; i++) if (d[i] && !m_lock[b*32+i]) m_out[b*32+i] = 1'b0;
    if (a >= 12'h100 && a < 12'h500) begin
      int p = int'((a - 12'h100) >> 2);
      if (p < NP && !m_lock[p]) m_ctrl[p] = d[8:0];
    end
    if (a[11:5] == 7'h28 && b < NB && m_armed) m_lock[b*32 +: 32] = d;
    m_armed = nxt;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    int b = int'(a[4:2]);
    if (a[11:5] == 7'h00 && b < NB) return m_out[b*32 +: 32];
    if (a[11:5] == 7'h01 && b < NB) return pad_in[b*32 +: 32];
    if (a[11:5] == 7'h28 && b < NB) return m_lock[b*32 +: 32];
    if (a >= 12'h100 && a < 12'h500) begin
      int p = int'((a - 12'h100) >> 2);
      if (p < NP) return 32'(m_ctrl[p]);
    end
    return 32'h0;
  endfunction

  function automatic logic [NP-1:0] exp_oe();
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = ~m_ctrl[p][0];
    return v;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a[11:2]; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v, output logic vld);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a[11:2];
    @(posedge clk); #1;
    bus_en = 1'b0;
    v = rd_data; vld = rd_valid;
  endtask

  task automatic rd_chk(input string tag, input logic [11:0] a);
    logic [31:0] v; logic vld;
    rd(a, v, vld);
    chk({tag, " rd_valid"}, 64'(vld), 64'd1);
    chk(tag, 64'(v), 64'(exp_read(a)));
  endtask

  task automatic pads_chk(input string tag);
    chk({tag, " pad_out"}, 64'(pad_out), 64'(m_out));
    chk({tag, " pad_oe"}, 64'(pad_oe), 64'(exp_oe()));
  endtask

  task automatic sync_probe(input int b, input logic [31:0] nv);
    logic [31:0] old, v; logic vld;
    old = pad_in[b*32 +: 32];
    @(negedge clk);
    pad_in[b*32 +: 32] = nv;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = 10'(12'h020 + 12'(4*b)) >> 0;
    bus_addr = 10'((12'h020 + 12'(4*b)) >> 2);
    @(posedge clk); #1;
    bus_en = 1'b0;
    chk("R9 same-edge read old", 64'(rd_data), 64'(old));
    rd(12'h020 + 12'(4*b), v, vld);
    chk("R9 second edge old", 64'(v), 64'(old));
    rd(12'h020 + 12'(4*b), v, vld);
    chk("R9 third edge new", 64'(v), 64'(nv));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v; logic vld;
    m_out = '0; m_lock = '1; m_armed = 1'b0;
    for (int p = 0; p < NP; p++) m_ctrl[p] = 9'd1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    pads_chk("R1 reset");
    rd_chk("R1 protect bank0", 12'h500);
    rd_chk("R1 protect bank1", 12'h504);
    for (int p = 0; p < NP; p++) rd_chk("R1 R2 ctrl reset", 12'(12'h100 + 4*p));
    rd_chk("R10 key reads zero", 12'h520);
    rd_chk("R10 irq area zero", 12'h084);
    @(posedge clk); #1;
    chk("R10 rd_valid idle", 64'(rd_valid), 64'd0);

    // R8 fully locked at reset
    wr(12'h040, 32'hFFFF_FFFF);
    wr(12'h100, 32'h0);
    pads_chk("R8 locked after reset");

    // R7 protect without key, disarm by other write, wrong password
    wr(12'h500, 32'h0);
    rd_chk("R7 no key", 12'h500);
    wr(12'h520, PW); wr(12'h044, 32'h1); wr(12'h500, 32'h0);
    rd_chk("R7 disarm by other write", 12'h500);
    wr(12'h520, 32'h00A5_A500); wr(12'h500, 32'h0);
    rd_chk("R7 wrong password", 12'h500);

    // R6 unlock both banks
    wr(12'h520, PW); wr(12'h500, 32'h0);
    wr(12'h520, PW); wr(12'h504, 32'h0);
    rd_chk("R6 unlock bank0", 12'h500);
    rd_chk("R6 unlock bank1", 12'h504);
    wr(12'h500, 32'hFFFF_FFFF);
    rd_chk("R6 R7 key consumed", 12'h500);

    // R5 and R2 control word sweep
    for (int p = 0; p < NP; p++) begin
      wr(12'(12'h100 + 4*p), 32'(((p * 13) << 1) | (p & 1)) & 32'h1FF);
      pads_chk("R5 direction");
      rd_chk("R2 ctrl map", 12'(12'h100 + 4*p));
    end

    // R3 R4 single-pin sweep
    for (int p = 0; p < NP; p++) begin
      wr(12'(12'h040 + 4*(p >> 5)), 32'h1 << (p & 31));
      pads_chk("R3 single set");
      rd_chk("R2 R5 out status", 12'(12'h000 + 4*(p >> 5)));
    end
    for (int p = 0; p < NP; p += 3) begin
      wr(12'(12'h060 + 4*(p >> 5)), 32'h1 << (p & 31));
      pads_chk("R4 single clear");
    end

    // R3 R4 patterns and zero bits
    wr(12'h060, 32'hFFFF_FFFF); pads_chk("R4 clear all bank0");
    wr(12'h040, 32'hA5A5_F00F); pads_chk("R3 pattern set");
    wr(12'h060, 32'h0F0F_FFF0); pads_chk("R4 pattern clear");
    wr(12'h044, 32'h1234_5678); pads_chk("R3 set bank1");
    wr(12'h044, 32'h0); pads_chk("R3 zero bits");
    wr(12'h064, 32'h0); pads_chk("R4 zero bits");
    rd_chk("R2 out status bank1", 12'h004);

    // R8 partial lock
    wr(12'h520, PW); wr(12'h500, 32'h0000_FFFF);
    rd_chk("R6 partial lock", 12'h500);
    wr(12'h040, 32'hFFFF_FFFF); pads_chk("R8 set partial");
    wr(12'h060, 32'hFFFF_FFFF); pads_chk("R8 clear partial");
    wr(12'h10C, 32'h1AA);
    rd_chk("R8 ctrl locked pin", 12'h10C);
    wr(12'h150, 32'h0AA);
    rd_chk("R8 ctrl open pin", 12'h150);
    pads_chk("R8 R5 after ctrl");

    // R9 synchroniser timing
    sync_probe(0, 32'hDEAD_BEEF);
    sync_probe(1, 32'h8000_0001);
    sync_probe(0, 32'h0);
    for (int i = 0; i < NP; i++) begin
      @(negedge clk); pad_in = 64'h1 << i;
      repeat (3) @(posedge clk);
      rd_chk("R9 walking input", 12'(12'h020 + 4*(i >> 5)));
    end

    // R10 absent banks and zero offsets
    wr(12'h054, 32'hFFFF_FFFF); pads_chk("R10 absent bank set");
    wr(12'h290, 32'h0);
    rd_chk("R10 absent bank status", 12'h014);
    rd_chk("R10 absent pin ctrl", 12'h290);
    rd_chk("R10 set reads zero", 12'h040);
    rd_chk("R10 clear reads zero", 12'h064);
    rd_chk("R10 absent protect", 12'h50C);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule